// File: doc/BRIEF.md
# Two-stage accumulator-clocked PWM controller

This block produces two pulse-width-modulated outputs from one system clock. Each channel has two stages. The first is a 16-bit phase accumulator: on every clock it adds a step derived from a programmable control word, so its top bit toggles at a fractional rate of the clock. The second is an 8-bit period counter that advances once each time the accumulator wraps. It compares its count against an on-time value to produce the duty cycle.

Software programs the step word, the on time and the period through a simple write port, and reads them back through a combinational read port. A shared control register holds four bits per channel: run, release, force-high and open-drain. A second register chooses, per channel, whether the pin carries the counter waveform or the raw accumulator top bit. Each pin is presented as a level plus an output-enable, so a pad ring can build a tri-state or open-drain driver from it.

Top module: `nco_pwm_ctrl`

## Requirements
- R1: After reset, the control register reads 0x22, so both channels are stopped and released. Every other register reads zero, and both `pwm_oe` bits are 0.
- R2: Each write takes effect in the clock edge at which `reg_wr` is high, and the registers read back through `reg_rdata` with unused bits as zero. The map is: control at 0x00 and select at 0x04, each 8 bits with a 4-bit field per channel at bit 4·ch. For channel ch, the step word high byte is at 0x08+8·ch, its low byte at 0x0C+8·ch, the on time at 0x18+8·ch and the period at 0x1C+8·ch. Each of these per-channel registers takes `reg_wdata[7:0]`.
- R3: While running, the accumulator adds a step W on each clock. W is the control word when it is below 0x8000; otherwise W is the 16-bit two's complement of the word. A wrap past 2^16 produces one counter tick, and the raw output is accumulator bit 15.
- R4: While the run bit (field bit 0) is low, the accumulator and the period counter are held at zero. The output level is then low unless force-high is set.
- R5: The counter period is period+1 ticks, and the level is high for the first `on` ticks of each period. If on exceeds period the level is high throughout; if on is 0 it is low throughout.
- R6: A new on or period value is applied only when the counter wraps at the end of a period, or at once while the channel is stopped.
- R7: Select bit 4·ch set to 1 routes the counter waveform to the pin, and set to 0 routes the raw accumulator bit 15.
- R8: Force-high (field bit 2) makes the level high whatever the run and select settings are.
- R9: Release (field bit 1) set to 1 forces `pwm_oe` to 0.
- R10: Open-drain (field bit 3) holds `pwm_out` at 0 and drives `pwm_oe` only while the level is low.
- R11: The channels run independently; a write to one channel's registers does not change the other channel's waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System and reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | 8 | Byte address for write and read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pwm_out | output | 2 | Per-channel output level (0 in open-drain mode) |
| pwm_oe | output | 2 | Per-channel output enable |

## Verification
Two events can land on the same clock: a register write to on or period, and the wrap at the end of a period that loads those values. A stop of the run bit can also coincide with an accumulator tick. The bench provokes both by sweeping the cycle at which on and period writes are issued against a running short period. A behavioural reference model, stepped on every clock, then judges both pins in every cycle. Direct high-cycle counts over whole periods also confirm that a write during a long period leaves the old duty in force until the wrap.

// File: rtl/pwm2s_pkg.sv
package pwm2s_pkg;
  localparam int FLD_W = 4;
  localparam int CW_W  = 16;
  localparam int BUS_W = 32;
  localparam int ADR_W = 8;

  typedef struct packed {
    logic odrain;
    logic force_hi;
    logic oe_n;
    logic run;
  } chan_ctl_t;

  localparam chan_ctl_t CTL_RST = '{odrain: 1'b0, force_hi: 1'b0, oe_n: 1'b1, run: 1'b0};
endpackage

// File: rtl/pwm2s_regs.sv
module pwm2s_regs
  import pwm2s_pkg::*;
#(
  parameter int NCH   = 2,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [ADR_W-1:0] addr,
  input  logic [BUS_W-1:0] wdata,
  output logic [BUS_W-1:0] rdata,
  output chan_ctl_t        ctl   [NCH],
  output logic             sel   [NCH],
  output logic [CW_W-1:0]  cw    [NCH],
  output logic [CNT_W-1:0] on_v  [NCH],
  output logic [CNT_W-1:0] per_v [NCH]
);
  localparam int CF_W    = FLD_W * NCH;
  localparam int ON_BASE = 8 + 8 * NCH;
  localparam logic [ADR_W-1:0] A_CTRL  = ADR_W'(0);
  localparam logic [ADR_W-1:0] A_CTRL2 = ADR_W'(4);

  function automatic logic [ADR_W-1:0] a_cwh(int c); return ADR_W'(8 + 8 * c); endfunction
  function automatic logic [ADR_W-1:0] a_cwl(int c); return ADR_W'(12 + 8 * c); endfunction
  function automatic logic [ADR_W-1:0] a_on(int c);  return ADR_W'(ON_BASE + 8 * c); endfunction
  function automatic logic [ADR_W-1:0] a_per(int c); return ADR_W'(ON_BASE + 4 + 8 * c); endfunction

  logic [CF_W-1:0]  ctrl_q, ctrl_d, ctrl2_q, ctrl2_d;
  logic [CW_W-1:0]  cw_q  [NCH];
  logic [CW_W-1:0]  cw_d  [NCH];
  logic [CNT_W-1:0] on_q  [NCH];
  logic [CNT_W-1:0] on_d  [NCH];
  logic [CNT_W-1:0] per_q [NCH];
  logic [CNT_W-1:0] per_d [NCH];
  logic             unused_wdata;

  assign unused_wdata = ^wdata[BUS_W-1:CF_W];

  always_comb begin
    ctrl_d  = ctrl_q;
    ctrl2_d = ctrl2_q;
    for (int c = 0; c < NCH; c++) begin
      cw_d[c]  = cw_q[c];
      on_d[c]  = on_q[c];
      per_d[c] = per_q[c];
    end
    if (wr) begin
      if (addr == A_CTRL)  ctrl_d  = wdata[CF_W-1:0];
      if (addr == A_CTRL2) ctrl2_d = wdata[CF_W-1:0];
      for (int c = 0; c < NCH; c++) begin
        if (addr == a_cwh(c)) cw_d[c][CW_W-1 -: 8] = wdata[7:0];
        if (addr == a_cwl(c)) cw_d[c][7:0]         = wdata[7:0];
        if (addr == a_on(c))  on_d[c]              = wdata[CNT_W-1:0];
        if (addr == a_per(c)) per_d[c]             = wdata[CNT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= {NCH{CTL_RST}};
      ctrl2_q <= '0;
      for (int c = 0; c < NCH; c++) begin
        cw_q[c]  <= '0;
        on_q[c]  <= '0;
        per_q[c] <= '0;
      end
    end else begin
      ctrl_q  <= ctrl_d;
      ctrl2_q <= ctrl2_d;
      for (int c = 0; c < NCH; c++) begin
        cw_q[c]  <= cw_d[c];
        on_q[c]  <= on_d[c];
        per_q[c] <= per_d[c];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == A_CTRL)  rdata[CF_W-1:0] = ctrl_q;
    if (addr == A_CTRL2) rdata[CF_W-1:0] = ctrl2_q;
    for (int c = 0; c < NCH; c++) begin
      if (addr == a_cwh(c)) rdata[7:0]       = cw_q[c][CW_W-1 -: 8];
      if (addr == a_cwl(c)) rdata[7:0]       = cw_q[c][7:0];
      if (addr == a_on(c))  rdata[CNT_W-1:0] = on_q[c];
      if (addr == a_per(c)) rdata[CNT_W-1:0] = per_q[c];
    end
  end

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      ctl[c]   = chan_ctl_t'(ctrl_q[FLD_W*c +: FLD_W]);
      sel[c]   = ctrl2_q[FLD_W*c];
      cw[c]    = cw_q[c];
      on_v[c]  = on_q[c];
      per_v[c] = per_q[c];
    end
  end
endmodule

// File: rtl/pwm2s_nco.sv
module pwm2s_nco #(
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [ACC_W-1:0] cw,
  output logic             tick,
  output logic             msb
);
  logic [ACC_W-1:0] acc_q, acc_d, step;
  logic [ACC_W:0]   sum;

  always_comb begin
    step  = cw[ACC_W-1] ? (~cw + ACC_W'(1)) : cw;
    sum   = {1'b0, acc_q} + {1'b0, step};
    acc_d = run ? sum[ACC_W-1:0] : '0;
    tick  = run & sum[ACC_W];
  end

  assign msb = acc_q[ACC_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  // R3: the step never exceeds half the range, so wraps are never back to back
  p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n) tick |=> !tick);
endmodule

// File: rtl/pwm2s_cfgen.sv
module pwm2s_cfgen #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] on_in,
  input  logic [CNT_W-1:0] per_in,
  output logic             wave_hi
);
  logic [CNT_W-1:0] cnt_q, cnt_d, on_q, on_d, per_q, per_d;
  logic             wrap;

  assign wrap = tick & (cnt_q == per_q);

  always_comb begin
    cnt_d = cnt_q;
    on_d  = on_q;
    per_d = per_q;
    if (!run) begin
      cnt_d = '0;
      on_d  = on_in;
      per_d = per_in;
    end else if (wrap) begin
      cnt_d = '0;
      on_d  = on_in;
      per_d = per_in;
    end else if (tick) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      on_q  <= '0;
      per_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      on_q  <= on_d;
      per_q <= per_d;
    end
  end

  assign wave_hi = cnt_q < on_q;

  // R5: the count stays within the active period
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n) run |-> (cnt_q <= per_q));
  // R6: active on/period change only at a wrap or while stopped
  p_shadow_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap) |=> ($stable(on_q) && $stable(per_q)));
endmodule

// File: rtl/pwm2s_pin.sv
module pwm2s_pin
  import pwm2s_pkg::*;
(
  input  chan_ctl_t ctl,
  input  logic      sel,
  input  logic      nco_msb,
  input  logic      wave_hi,
  output logic      out,
  output logic      oe
);
  logic level;

  always_comb begin
    level = ctl.force_hi | (ctl.run & (sel ? wave_hi : nco_msb));
    oe    = ~ctl.oe_n & (~ctl.odrain | ~level);
    out   = ~ctl.odrain & level;
  end
endmodule

// File: rtl/nco_pwm_ctrl.sv
module nco_pwm_ctrl
  import pwm2s_pkg::*;
#(
  parameter int NCH   = 2,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [ADR_W-1:0] reg_addr,
  input  logic [BUS_W-1:0] reg_wdata,
  output logic [BUS_W-1:0] reg_rdata,
  output logic [NCH-1:0]   pwm_out,
  output logic [NCH-1:0]   pwm_oe
);
  logic [1:0]       rst_sync;
  logic             rst_s;
  chan_ctl_t        ctl   [NCH];
  logic             sel   [NCH];
  logic [CW_W-1:0]  cw    [NCH];
  logic [CNT_W-1:0] on_v  [NCH];
  logic [CNT_W-1:0] per_v [NCH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s = rst_sync[1];

  pwm2s_regs #(.NCH(NCH), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_s), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .ctl(ctl), .sel(sel), .cw(cw), .on_v(on_v), .per_v(per_v)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic tick, msb, wave_hi;

    pwm2s_nco #(.ACC_W(CW_W)) u_nco (
      .clk(clk), .rst_n(rst_s), .run(ctl[g].run), .cw(cw[g]), .tick(tick), .msb(msb)
    );

    pwm2s_cfgen #(.CNT_W(CNT_W)) u_cfgen (
      .clk(clk), .rst_n(rst_s), .run(ctl[g].run), .tick(tick),
      .on_in(on_v[g]), .per_in(per_v[g]), .wave_hi(wave_hi)
    );

    pwm2s_pin u_pin (
      .ctl(ctl[g]), .sel(sel[g]), .nco_msb(msb), .wave_hi(wave_hi),
      .out(pwm_out[g]), .oe(pwm_oe[g])
    );

    // R9: a released channel never enables its pin
    p_release_r9: assert property (@(posedge clk) disable iff (!rst_s)
      ctl[g].oe_n |-> !pwm_oe[g]);
    // R10: open-drain never presents a high level
    p_od_low_r10: assert property (@(posedge clk) disable iff (!rst_s)
      ctl[g].odrain |-> !pwm_out[g]);
  end
endmodule

// File: tb/nco_pwm_ctrl_tb_top.sv
`timescale 1ns/1ps
module nco_pwm_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [1:0]  pwm_out, pwm_oe;

  always #2.5 clk = ~clk;

  nco_pwm_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out), .pwm_oe(pwm_oe)
  );

  int    total = 0, bad = 0, cyc = 0;
  string cur_req = "R1";
  bit    cmp_on = 0;

  // behavioural reference model
  int m_ctrl, m_ctrl2;
  int m_cw[2], m_on[2], m_per[2], m_acc[2], m_cnt[2], m_ona[2], m_pera[2];

  function automatic int fbit(int v, int c, int b); return (v >> (4*c + b)) & 1; endfunction

  function automatic int m_lvl(int c);
    int r;
    if (fbit(m_ctrl, c, 2) == 1) return 1;
    if (fbit(m_ctrl, c, 0) == 0) return 0;
    if (fbit(m_ctrl2, c, 0) == 1) r = (m_cnt[c] < m_ona[c]) ? 1 : 0;
    else r = (m_acc[c] >= 32768) ? 1 : 0;
    return r;
  endfunction

  function automatic int m_out(int c);
    return (fbit(m_ctrl, c, 3) == 1) ? 0 : m_lvl(c);
  endfunction

  function automatic int m_oe(int c);
    if (fbit(m_ctrl, c, 1) == 1) return 0;
    if (fbit(m_ctrl, c, 3) == 1) return (m_lvl(c) == 0) ? 1 : 0;
    return 1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 'h22; m_ctrl2 = 0;
      for (int c = 0; c < 2; c++) begin
        m_cw[c] = 0; m_on[c] = 0; m_per[c] = 0;
        m_acc[c] = 0; m_cnt[c] = 0; m_ona[c] = 0; m_pera[c] = 0;
      end
    end else begin
      for (int c = 0; c < 2; c++) begin
        if (fbit(m_ctrl, c, 0) == 0) begin
          m_acc[c] = 0; m_cnt[c] = 0; m_ona[c] = m_on[c]; m_pera[c] = m_per[c];
        end else begin
          int w, s;
          w = (m_cw[c] < 32768) ? m_cw[c] : 65536 - m_cw[c];
          s = m_acc[c] + w;
          m_acc[c] = s % 65536;
          if (s >= 65536) begin
            if (m_cnt[c] == m_pera[c]) begin
              m_cnt[c] = 0; m_ona[c] = m_on[c]; m_pera[c] = m_per[c];
            end else m_cnt[c] = m_cnt[c] + 1;
          end
        end
      end
      if (reg_wr) begin
        int a, d;
        a = int'(reg_addr); d = int'(reg_wdata[7:0]);
        if (a == 0) m_ctrl = d;
        if (a == 4) m_ctrl2 = d;
        for (int c = 0; c < 2; c++) begin
          if (a == 8 + 8*c)  m_cw[c] = (m_cw[c] & 'hFF) | (d << 8);
          if (a == 12 + 8*c) m_cw[c] = (m_cw[c] & 'hFF00) | d;
          if (a == 24 + 8*c) m_on[c] = d;
          if (a == 28 + 8*c) m_per[c] = d;
        end
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model, tagged with the requirement under test
  always @(negedge clk) begin
    if (cmp_on) begin
      for (int c = 0; c < 2; c++) begin
        chk({cur_req, " pin level"}, int'(pwm_out[c]), m_out(c));
        chk({cur_req, " pin enable"}, int'(pwm_oe[c]), m_oe(c));
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000) begin
      total++; bad++;
      $display("FAIL watchdog (all requirements): act=%0d exp=%0d", cyc, 60000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic idle(int n); repeat (n) @(negedge clk); endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 8'(a); reg_wdata = 32'(d);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(string tag, int a, int exp);
    @(negedge clk);
    reg_addr = 8'(a);
    #1;
    chk(tag, int'(reg_rdata), exp);
  endtask

  // counts high samples of pwm_out (what=0) or pwm_oe (what=1) over n cycles
  task automatic cnt_hi(int c, int what, int n, output int k);
    k = 0;
    repeat (n) begin
      @(negedge clk);
      k += (what == 0) ? int'(pwm_out[c]) : int'(pwm_oe[c]);
    end
  endtask

  initial begin
    int k;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    @(posedge clk);
    cmp_on = 1;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1: reset values
    cur_req = "R1";
    rd_chk("R1 control reset", 'h00, 'h22);
    rd_chk("R1 step word reset", 'h08, 0);
    rd_chk("R1 on reset", 'h18, 0);
    rd_chk("R1 period reset", 'h24, 0);
    chk("R1 pins released", int'(pwm_oe), 0);

    // R2: map and readback
    cur_req = "R2";
    wr('h04, 'h1F);        rd_chk("R2 select readback", 'h04, 'h1F);
    wr('h24, 'h1C5);       rd_chk("R2 period ch1 readback", 'h24, 'hC5);
    wr('h10, 'hAB);        rd_chk("R2 step hi ch1", 'h10, 'hAB);
    wr('h14, 'hCD);        rd_chk("R2 step lo ch1", 'h14, 'hCD);
    wr('h1C, 'h33);        rd_chk("R2 period ch0", 'h1C, 'h33);
    wr('h04, 0); wr('h24, 0); wr('h10, 0); wr('h14, 0); wr('h1C, 0);

    // R3: raw accumulator output, half of each wrap interval high
    cur_req = "R3";
    wr('h08, 'h40); wr('h0C, 0); wr('h00, 'h21);
    idle(10); cnt_hi(0, 0, 64, k); chk("R3 step 0x4000 duty", k, 32);
    wr('h08, 'hC0);
    idle(10); cnt_hi(0, 0, 64, k); chk("R3 step 0xC000 two's complement duty", k, 32);
    wr('h08, 'h10);
    idle(20); cnt_hi(0, 0, 64, k); chk("R3 step 0x1000 duty", k, 32);

    // R5 and R7: counter waveform on the pin
    cur_req = "R5";
    wr('h08, 'h80); wr('h1C, 3); wr('h18, 1); wr('h04, 'h01);
    idle(40); cnt_hi(0, 0, 64, k); chk("R5 on=1 period=3", k, 16);
    wr('h18, 5);
    idle(40); cnt_hi(0, 0, 64, k); chk("R5 on above period", k, 64);
    wr('h18, 0);
    idle(40); cnt_hi(0, 0, 64, k); chk("R5 on zero", k, 0);
    wr('h18, 4);
    idle(40); cnt_hi(0, 0, 64, k); chk("R5 on=period+1", k, 64);
    cur_req = "R7";
    wr('h04, 'h00);
    idle(10); cnt_hi(0, 0, 64, k); chk("R7 raw selected", k, 32);
    wr('h04, 'h01); wr('h18, 1);

    // R6: writes landing on every phase of a short period
    cur_req = "R6";
    wr('h1C, 7); wr('h18, 2); idle(40);
    for (int d = 0; d < 10; d++) begin
      idle(d);
      wr('h18, d % 9);
      idle(3);
      wr('h1C, 3 + d % 5);
      idle(20);
    end
    wr('h00, 'h20); wr('h1C, 100); wr('h18, 0); wr('h00, 'h21);
    wr('h18, 100);
    cnt_hi(0, 0, 100, k); chk("R6 on write deferred to wrap", k, 0);
    idle(400);

    // R4: stopping holds the level low
    cur_req = "R4";
    wr('h1C, 1); wr('h18, 1); idle(20);
    wr('h00, 'h20);
    cnt_hi(0, 0, 20, k); chk("R4 stopped level", k, 0);
    cnt_hi(0, 1, 20, k); chk("R4 stopped pin still enabled", k, 20);

    // R8: force-high with and without run
    cur_req = "R8";
    wr('h00, 'h24); cnt_hi(0, 0, 20, k); chk("R8 force without run", k, 20);
    wr('h00, 'h25); cnt_hi(0, 0, 20, k); chk("R8 force with run", k, 20);

    // R9: release
    cur_req = "R9";
    wr('h00, 'h23); cnt_hi(0, 1, 20, k); chk("R9 released enable", k, 0);

    // R10: open-drain, level=1 for 2 of 8 clocks
    cur_req = "R10";
    wr('h00, 'h20); wr('h1C, 3); wr('h18, 1); wr('h00, 'h29);
    idle(8);
    cnt_hi(0, 0, 64, k); chk("R10 open-drain never high", k, 0);
    cnt_hi(0, 1, 64, k); chk("R10 open-drain drives low phase", k, 48);

    // R11: both channels at once
    cur_req = "R11";
    wr('h00, 'h01);
    wr('h10, 'h20); wr('h14, 0); wr('h24, 1); wr('h20, 1); wr('h04, 'h11); wr('h00, 'h11);
    idle(40);
    cnt_hi(0, 0, 64, k); chk("R11 channel 0 duty", k, 16);
    cnt_hi(1, 0, 64, k); chk("R11 channel 1 duty", k, 32);
    wr('h18, 3);
    idle(20); cnt_hi(1, 0, 64, k); chk("R11 channel 1 unaffected by ch0 write", k, 32);

    cmp_on = 0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule